// File: doc/BRIEF.md
# Dual-Channel One-Time-Programmable Wiper Controller

This block keeps the two 8-bit wiper codes of a 256-position, two-channel digital potentiometer. A small parallel command port, standing in for the serial bus, writes a wiper, reads it back together with its fused flag, or starts the one-time fuse burn for one channel. The fuse bank is a write-once register bank, and it survives the power-up reset. A channel with no fuse wakes at midscale. A fused channel wakes at its burned value. After the burn, the wiper can still be changed freely until the next power-up.

A burn takes a parameterised number of cycles, `PROG_CYCLES`, and `busy` stays high the whole time. While the burn runs, reads are still served. Writes and burn requests are refused and raise a sticky flag. A second burn of a channel that is already fused is refused and raises a separate sticky flag.

Top module: `otp_wiper_ctrl`

## Requirements
- R1: While `rstN` is low with no fuse burned, and on the first cycle after release, both wipers read 0x80 on `wiperCodes`. In the same window, `busy`, `errFuse`, `errBusy` and `fusedFlags` are all 0.
- R2: Command codes on `cmdOp` are 0 = no-op, 1 = write, 2 = read, 3 = burn. An accepted write loads `cmdData` into the wiper of channel `cmdCh` at the next clock edge. The other wiper is unchanged. Channel 0 sits in `wiperCodes[7:0]` and channel 1 in `wiperCodes[15:8]`.
- R3: A read makes `rdValid` high for exactly one cycle, starting the cycle after the command. In that cycle, `rdData` holds the channel's wiper code and `rdFused` holds its fused flag.
- R4: A burn of an unfused channel raises `busy` the cycle after the command and holds it for exactly `PROG_CYCLES` cycles. On the cycle `busy` falls, the channel's bit in `fusedFlags` is set. The fused value is the wiper code at the time of the command.
- R5: After a channel is fused, writes to it are still accepted and change its wiper.
- R6: A `rstN` pulse restores each fused channel to its fused value and each unfused channel to 0x80.
- R7: A burn of a channel that is already fused starts no burn and leaves its fused value unchanged. It sets `errFuse`, which stays set until `rstN`.
- R8: A write or burn presented while `busy` is high is rejected. This includes the final busy cycle. The wiper keeps its value, and `errBusy` is set and stays set until `rstN`.
- R9: A read presented while `busy` is high is served as in R3.
- R10: The fuse bank and `fusedFlags` survive `rstN`. Only `fuseClear`, applied with `rstN` low, clears them, after which reset gives 0x80 on both channels.
- R11: A no-op command changes no wiper and raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-up reset, synchronous |
| fuseClear | input | 1 | Simulation-only fuse bank initialise |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 2 | 0 no-op, 1 write, 2 read, 3 burn |
| cmdCh | input | 1 | Target channel |
| cmdData | input | 8 | Write data |
| wiperCodes | output | 16 | Live wiper codes, channel 0 in low byte |
| fusedFlags | output | 2 | Per-channel fused status |
| busy | output | 1 | Fuse burn in progress |
| errFuse | output | 1 | Sticky: burn of an already fused channel |
| errBusy | output | 1 | Sticky: write or burn refused while busy |
| rdValid | output | 1 | Read data valid |
| rdData | output | 8 | Read wiper code |
| rdFused | output | 1 | Read fused flag |

## Verification
The burn completion and a new command can fall in the same cycle. In that cycle the counter reaches its end, the fuse is committed, and `busy` is still high. The bench provokes this by issuing a write exactly on the final busy cycle. It judges the result by checking four things on the next cycle: `busy` has fallen, the fuse flag is set, the wiper kept its pre-burn value, and `errBusy` is raised. A read issued inside the burn window likewise has to be answered while the burn continues undisturbed.

// File: rtl/otp_wiper_pkg.sv
package otp_wiper_pkg;

  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_BURN  = 2'd3
  } cmd_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_PROG = 1'b1
  } ctrl_state_e;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic wrStb;     // load cmdData into wiper[cmdCh]
    logic rdStb;     // capture wiper[cmdCh] and its fused flag
    logic capStb;    // latch wiper[cmdCh] as the value to burn
    logic commitStb; // write latched value into fuse bank of progCh
  } dp_strobe_t;

endpackage

// File: rtl/otp_wiper_ctrl_fsm.sv
module otp_wiper_ctrl_fsm
  import otp_wiper_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int PROG_CYCLES = 50_000_000,
  parameter int CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [CH_W-1:0]   cmdCh,
  input  logic [NUM_CH-1:0] fusedVec,
  output dp_strobe_t        strb,
  output logic [CH_W-1:0]   progCh,
  output logic              busy,
  output logic              errFuse,
  output logic              errBusy
);

  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PROG_CYCLES - 1);

  ctrl_state_e      state;
  logic [CNT_W-1:0] cnt;
  cmd_op_e          op;
  logic             chOk;
  logic             tgtFused;
  logic             cmdLive;

  assign op       = cmd_op_e'(cmdOp);
  assign chOk     = (int'(cmdCh) < NUM_CH);
  assign tgtFused = chOk ? fusedVec[cmdCh] : 1'b0;
  assign cmdLive  = rstN && cmdValid && chOk;
  assign busy     = (state == ST_PROG);

  always_comb begin
    strb = '0;
    if (cmdLive) begin
      if (state == ST_IDLE) begin
        case (op)
          OP_WRITE: strb.wrStb  = 1'b1;
          OP_READ:  strb.rdStb  = 1'b1;
          OP_BURN:  strb.capStb = !tgtFused;
          default:  ;
        endcase
      end else if (op == OP_READ) begin
        strb.rdStb = 1'b1;
      end
    end
    if (rstN && state == ST_PROG && cnt == '0) strb.commitStb = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      progCh  <= '0;
      errFuse <= 1'b0;
      errBusy <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (strb.capStb) begin
            state  <= ST_PROG;
            cnt    <= CNT_LOAD;
            progCh <= cmdCh;
          end
          if (cmdLive && op == OP_BURN && tgtFused) errFuse <= 1'b1;
        end
        default: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
          if (cmdLive && (op == OP_WRITE || op == OP_BURN)) errBusy <= 1'b1;
        end
      endcase
    end
  end

  // R7: burn-error flag is sticky until reset
  a_r7_errfuse_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $past(errFuse) && $past(rstN) |-> errFuse);

  // R8: busy-error flag is sticky until reset
  a_r8_errbusy_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $past(errBusy) && $past(rstN) |-> errBusy);

  // R4: a burn only starts from idle, never stacks on a running one
  a_r4_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy) && $past(rstN) && $past(cnt) != '0 |-> busy);

endmodule

// File: rtl/otp_wiper_datapath.sv
module otp_wiper_datapath
  import otp_wiper_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CODE_W = 8,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     fuseClear,
  input  dp_strobe_t               strb,
  input  logic [CH_W-1:0]          cmdCh,
  input  logic [CODE_W-1:0]        cmdData,
  input  logic [CH_W-1:0]          progCh,
  input  logic                     busy,
  output logic [NUM_CH*CODE_W-1:0] wiperFlat,
  output logic [NUM_CH-1:0]        fusedVec,
  output logic                     rdValid,
  output logic [CODE_W-1:0]        rdData,
  output logic                     rdFused
);

  localparam logic [CODE_W-1:0] MIDSCALE = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] wiperQ   [NUM_CH];
  logic [CODE_W-1:0] fuseValQ [NUM_CH];
  logic [NUM_CH-1:0] fusedQ;
  logic [CODE_W-1:0] burnVal;

  assign fusedVec = fusedQ;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // volatile wiper: power-up preset comes from the fuse bank
    always_ff @(posedge clk) begin
      if (!rstN)
        wiperQ[c] <= (!fuseClear && fusedQ[c]) ? fuseValQ[c] : MIDSCALE;
      else if (strb.wrStb && cmdCh == CH_W'(c))
        wiperQ[c] <= cmdData;
    end

    // write-once fuse bank, untouched by rstN
    always_ff @(posedge clk) begin
      if (fuseClear) begin
        fusedQ[c]   <= 1'b0;
        fuseValQ[c] <= '0;
      end else if (strb.commitStb && progCh == CH_W'(c) && !fusedQ[c]) begin
        fusedQ[c]   <= 1'b1;
        fuseValQ[c] <= burnVal;
      end
    end

    assign wiperFlat[c*CODE_W +: CODE_W] = wiperQ[c];

    // R7: once set, a fuse never clears or changes outside fuseClear
    a_r7_fuse_write_once: assert property (@(posedge clk) disable iff (fuseClear)
      $past(fusedQ[c]) && !$past(fuseClear) |-> fusedQ[c] && $stable(fuseValQ[c]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) burnVal <= '0;
    else if (strb.capStb) burnVal <= wiperQ[cmdCh];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
      rdFused <= 1'b0;
    end else begin
      rdValid <= strb.rdStb;
      if (strb.rdStb) begin
        rdData  <= wiperQ[cmdCh];
        rdFused <= fusedQ[cmdCh];
      end
    end
  end

  // R8: no wiper moves at an edge where control was busy
  a_r8_wiper_frozen_busy: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy) && $past(rstN) |-> $stable(wiperFlat));

  // R4: the end of a burn leaves the target channel fused
  a_r4_fall_sets_fuse: assert property (@(posedge clk) disable iff (!rstN || fuseClear)
    $fell(busy) && $past(rstN) |-> fusedQ[progCh]);

  // R3: read data valid is a single-cycle pulse unless reads are back to back
  a_r3_rd_follows_strobe: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(strb.rdStb));

endmodule

// File: rtl/otp_wiper_ctrl.sv
module otp_wiper_ctrl
  import otp_wiper_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int CODE_W      = 8,
  parameter int PROG_CYCLES = 50_000_000,
  parameter int CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     fuseClear,
  input  logic                     cmdValid,
  input  logic [1:0]               cmdOp,
  input  logic [CH_W-1:0]          cmdCh,
  input  logic [CODE_W-1:0]        cmdData,
  output logic [NUM_CH*CODE_W-1:0] wiperCodes,
  output logic [NUM_CH-1:0]        fusedFlags,
  output logic                     busy,
  output logic                     errFuse,
  output logic                     errBusy,
  output logic                     rdValid,
  output logic [CODE_W-1:0]        rdData,
  output logic                     rdFused
);

  dp_strobe_t      strb;
  logic [CH_W-1:0] progCh;

  otp_wiper_ctrl_fsm #(
    .NUM_CH(NUM_CH), .PROG_CYCLES(PROG_CYCLES), .CH_W(CH_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdCh(cmdCh), .fusedVec(fusedFlags), .strb(strb), .progCh(progCh),
    .busy(busy), .errFuse(errFuse), .errBusy(errBusy)
  );

  otp_wiper_datapath #(
    .NUM_CH(NUM_CH), .CODE_W(CODE_W), .CH_W(CH_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .fuseClear(fuseClear), .strb(strb),
    .cmdCh(cmdCh), .cmdData(cmdData), .progCh(progCh), .busy(busy),
    .wiperFlat(wiperCodes), .fusedVec(fusedFlags), .rdValid(rdValid),
    .rdData(rdData), .rdFused(rdFused)
  );

endmodule

// File: tb/sim_otp_wiper_ctrl.sv
`timescale 1ns/1ps
module sim_otp_wiper_ctrl;

  localparam int P = 16;

  logic        clk = 1'b0;
  logic        rstN, fuseClear, cmdValid;
  logic [1:0]  cmdOp;
  logic [0:0]  cmdCh;
  logic [7:0]  cmdData;
  logic [15:0] wiperCodes;
  logic [1:0]  fusedFlags;
  logic        busy, errFuse, errBusy, rdValid, rdFused;
  logic [7:0]  rdData;

  int testCnt = 0;
  int failCnt = 0;

  always #4 clk = ~clk;

  otp_wiper_ctrl #(.NUM_CH(2), .CODE_W(8), .PROG_CYCLES(P)) u0 (
    .clk(clk), .rstN(rstN), .fuseClear(fuseClear), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdCh(cmdCh), .cmdData(cmdData), .wiperCodes(wiperCodes),
    .fusedFlags(fusedFlags), .busy(busy), .errFuse(errFuse), .errBusy(errBusy),
    .rdValid(rdValid), .rdData(rdData), .rdFused(rdFused)
  );

  // vector: op[34:33] ch[32] data[31:24] exp0[23:16] exp1[15:8] expRd[7:0]
  localparam logic [34:0] TBL [8] = '{
    {2'd1, 1'b0, 8'h12, 8'h12, 8'h80, 8'h00},
    {2'd1, 1'b1, 8'hFF, 8'h12, 8'hFF, 8'h00},
    {2'd1, 1'b0, 8'h00, 8'h00, 8'hFF, 8'h00},
    {2'd0, 1'b0, 8'h55, 8'h00, 8'hFF, 8'h00},
    {2'd1, 1'b1, 8'h01, 8'h00, 8'h01, 8'h00},
    {2'd2, 1'b1, 8'h00, 8'h00, 8'h01, 8'h01},
    {2'd1, 1'b0, 8'h80, 8'h80, 8'h01, 8'h00},
    {2'd1, 1'b0, 8'hA5, 8'hA5, 8'h01, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doCmd(input logic [1:0] op, input logic ch, input logic [7:0] d);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdCh = ch; cmdData = d;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 2'd0;
  endtask

  task automatic pulseReset(input logic clr);
    @(negedge clk);
    rstN = 1'b0; fuseClear = clr;
    repeat (3) @(negedge clk);
    rstN = 1'b1; fuseClear = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    rstN = 1'b0; fuseClear = 1'b1; cmdValid = 1'b0;
    cmdOp = 2'd0; cmdCh = 1'b0; cmdData = 8'h00;
    repeat (3) @(negedge clk);
    fuseClear = 1'b0;
    // R1: state while reset is held
    chk("R1 wipers in reset", 32'(wiperCodes), 32'h8080);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chk("R1 wipers after reset", 32'(wiperCodes), 32'h8080);
    chk("R1 flags", {busy, errFuse, errBusy, fusedFlags}, 0);

    // R2 / R3 / R11: table of commands
    for (int i = 0; i < 8; i++) begin
      doCmd(TBL[i][34:33], TBL[i][32], TBL[i][31:24]);
      chk($sformatf("R2 wiper0 vec%0d", i), 32'(wiperCodes[7:0]), 32'(TBL[i][23:16]));
      chk($sformatf("R2 wiper1 vec%0d", i), 32'(wiperCodes[15:8]), 32'(TBL[i][15:8]));
      if (TBL[i][34:33] == 2'd2) begin
        chk("R3 rdValid", 32'(rdValid), 1);
        chk("R3 rdData", 32'(rdData), 32'(TBL[i][7:0]));
        @(negedge clk);
        chk("R3 rdValid one cycle", 32'(rdValid), 0);
      end
      if (TBL[i][34:33] == 2'd0) chk("R11 nop no flags", {errFuse, errBusy}, 0);
    end

    // R4: burn channel 0 (value A5)
    doCmd(2'd3, 1'b0, 8'h00);
    for (int i = 0; i < P; i++) begin
      chk($sformatf("R4 busy cycle %0d", i), 32'(busy), 1);
      @(negedge clk);
    end
    chk("R4 busy falls", 32'(busy), 0);
    chk("R4 fused ch0", 32'(fusedFlags), 32'h1);
    doCmd(2'd2, 1'b0, 8'h00);
    chk("R3 rdFused ch0", {rdValid, rdFused, rdData}, {2'b11, 8'hA5});

    // R5: write after burn
    doCmd(2'd1, 1'b0, 8'h33);
    chk("R5 wiper0 post-burn write", 32'(wiperCodes[7:0]), 32'h33);

    // R7: second burn refused
    doCmd(2'd3, 1'b0, 8'h00);
    chk("R7 no busy", 32'(busy), 0);
    chk("R7 errFuse", 32'(errFuse), 1);
    repeat (2) @(negedge clk);
    chk("R7 errFuse sticky", 32'(errFuse), 1);

    // R9 / R8: burn channel 1, read and write while busy
    doCmd(2'd3, 1'b1, 8'h00);
    doCmd(2'd2, 1'b1, 8'h00);
    chk("R9 read while busy", {busy, rdValid, rdData}, {2'b11, 8'h01});
    doCmd(2'd1, 1'b1, 8'h77);
    chk("R8 write rejected", 32'(wiperCodes[15:8]), 32'h01);
    chk("R8 errBusy", 32'(errBusy), 1);
    for (int i = 0; i < P && busy; i++) @(negedge clk);
    chk("R4 fused both", 32'(fusedFlags), 32'h3);

    // R6 / R10: reset restores fused values, fuses and errors
    pulseReset(1'b0);
    @(negedge clk);
    chk("R6 restore fused values", 32'(wiperCodes), 32'h01A5);
    chk("R10 fuses survive reset", 32'(fusedFlags), 32'h3);
    chk("R10 errors cleared by reset", {errFuse, errBusy}, 0);

    // R10: fuse clear
    pulseReset(1'b1);
    @(negedge clk);
    chk("R10 fuse clear", {fusedFlags, wiperCodes}, {2'b00, 16'h8080});

    // R8: write on the final busy cycle
    doCmd(2'd1, 1'b1, 8'h44);
    doCmd(2'd3, 1'b1, 8'h00);
    repeat (P - 2) @(negedge clk);
    doCmd(2'd1, 1'b1, 8'h99);
    chk("R8 last-cycle busy done", 32'(busy), 0);
    chk("R8 last-cycle fused", 32'(fusedFlags), 32'h2);
    chk("R8 last-cycle write rejected", 32'(wiperCodes[15:8]), 32'h44);
    chk("R8 last-cycle errBusy", 32'(errBusy), 1);

    // R6: one fused, one not
    doCmd(2'd1, 1'b1, 8'hEE);
    pulseReset(1'b0);
    @(negedge clk);
    chk("R6 mixed restore", 32'(wiperCodes), 32'h4480);

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule